// File: doc/BRIEF.md
# Memory-Mapped Interval Timer

This block is a 32-bit up-counting interval timer. A processor reaches it over a plain word bus made of a byte offset, a write strobe, write data and combinational read data. A programmable divider sets how often the counter steps. The counter climbs to a software-chosen limit, then falls back to zero. Each time it arrives at the limit it can latch a flag and send a single-cycle interrupt pulse.

The register window also holds a group of configuration words that only store data and are read back as written. Software uses them as scratch space; they drive no logic. The only status field is the update flag. Software clears it by writing a zero into its bit, so a read-modify-write that does not touch the flag leaves it alone. Offsets that the map does not decode read as zero, and writes to them are dropped.

Top module: `gpt_interval_timer`

## Requirements
- R1: After the synchronous reset every mapped register reads zero, including counter, divider and limit, and the interrupt output is low.
- R2: A write to any mapped configuration offset (storage words at 0x04, 0x08, 0x14, 0x18, 0x1C, 0x20, 0x34, 0x38, 0x3C, 0x40, 0x48, 0x4C, 0x50, plus control 0x00, interrupt enable 0x0C, divider 0x28 and limit 0x2C) is read back unchanged from the cycle after the write strobe.
- R3: A read at an unmapped or misaligned offset (for example 0x30, 0x44, 0x54, 0x7C, 0x01) returns zero, and a write there changes no mapped register.
- R4: The counter (offset 0x24) steps only while bit 0 of the control word (offset 0x00) is 1; while it is 0 the counter holds its value.
- R5: With divider value D at offset 0x28, the counter steps once every D+1 clock cycles. From reset the first step comes D+1 cycles after the enabling write takes effect.
- R6: When the counter has arrived at the limit value L (offset 0x2C), the next counting step returns it to zero.
- R7: The counting step that brings the counter to L sets bit 0 of the status word (offset 0x10) and drives the interrupt output high for exactly one cycle, on the cycle after that step. This happens only when the interrupt enable word (offset 0x0C) equals exactly 0x1; any other enable value produces neither the flag nor the pulse.
- R8: A write to the status word ANDs the written data into it: a 1 in bit 0 keeps the flag and a 0 clears it.
- R9: A limit value of zero keeps the counter at zero and produces no flag and no interrupt.
- R10: A software write to the counter takes effect on the next clock, and the next arrival at the limit is counted from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe, captured at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Registered one-cycle update interrupt |

## Verification
The hardest case to reach is the exact cycle of an update event, because it depends on the divider phase, the counter value and the limit all at once. The stimulus resets the block before each timing test, so the divider phase starts from zero. It then loads the limit and the counter with the counter stopped, and enables counting with one write. From that known start the cycle of the interrupt is a fixed number of clocks away. The case of an enable word that is nonzero but not 0x1 is run across several counter wraps to show that no flag or pulse is produced.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned MAP_AW = 7;

  localparam logic [MAP_AW-1:0] A_CTRL   = 7'h00;
  localparam logic [MAP_AW-1:0] A_AUX    = 7'h04;
  localparam logic [MAP_AW-1:0] A_SLAVE  = 7'h08;
  localparam logic [MAP_AW-1:0] A_IEN    = 7'h0C;
  localparam logic [MAP_AW-1:0] A_STAT   = 7'h10;
  localparam logic [MAP_AW-1:0] A_EVGEN  = 7'h14;
  localparam logic [MAP_AW-1:0] A_CM0    = 7'h18;
  localparam logic [MAP_AW-1:0] A_CM1    = 7'h1C;
  localparam logic [MAP_AW-1:0] A_CAPEN  = 7'h20;
  localparam logic [MAP_AW-1:0] A_COUNT  = 7'h24;
  localparam logic [MAP_AW-1:0] A_DIV    = 7'h28;
  localparam logic [MAP_AW-1:0] A_RELOAD = 7'h2C;
  localparam logic [MAP_AW-1:0] A_CMP0   = 7'h34;
  localparam logic [MAP_AW-1:0] A_CMP1   = 7'h38;
  localparam logic [MAP_AW-1:0] A_CMP2   = 7'h3C;
  localparam logic [MAP_AW-1:0] A_CMP3   = 7'h40;
  localparam logic [MAP_AW-1:0] A_XCFG   = 7'h48;
  localparam logic [MAP_AW-1:0] A_XADR   = 7'h4C;
  localparam logic [MAP_AW-1:0] A_OPT    = 7'h50;

  // storage-only words: they hold data and drive nothing
  localparam int unsigned N_PLAIN = 13;
  localparam logic [MAP_AW-1:0] PLAIN_MAP [N_PLAIN] = '{
    A_OPT, A_XADR, A_XCFG, A_CMP3, A_CMP2, A_CMP1, A_CMP0,
    A_CAPEN, A_CM1, A_CM0, A_EVGEN, A_SLAVE, A_AUX
  };

  // enable word value that arms the update interrupt
  localparam int unsigned IEN_ARMED = 1;
endpackage

// File: rtl/gpt_plain_bank.sv
module gpt_plain_bank
  import gpt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = N_PLAIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAP_AW-1:0] addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic              hit,
  output logic [DW-1:0]     rdata
);
  logic [N-1:0]  sel_v;
  logic [DW-1:0] q_v [N];

  for (genvar g = 0; g < N; g++) begin : g_word
    assign sel_v[g] = (addr == PLAIN_MAP[g]);
    always_ff @(posedge clk) begin
      if (rst)
        q_v[g] <= '0;
      else if (wr && sel_v[g])
        q_v[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (sel_v[i]) rdata = rdata | q_v[i];
  end

  assign hit = |sel_v;
endmodule

// File: rtl/gpt_ctrl_regs.sv
module gpt_ctrl_regs
  import gpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAP_AW-1:0] addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              upd_evt,
  output logic              cen,
  output logic              ien_ok,
  output logic              stat_flag,
  output logic [DW-1:0]     div_val,
  output logic [DW-1:0]     reload_val,
  output logic              hit,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] ctrl_q, ien_q, stat_q, div_q, reload_q, stat_nxt;
  logic sel_ctrl, sel_ien, sel_stat, sel_div, sel_rel;

  assign sel_ctrl = (addr == A_CTRL);
  assign sel_ien  = (addr == A_IEN);
  assign sel_stat = (addr == A_STAT);
  assign sel_div  = (addr == A_DIV);
  assign sel_rel  = (addr == A_RELOAD);

  // write-AND first, a same-cycle hardware event still sets the flag
  always_comb begin
    stat_nxt = stat_q;
    if (wr && sel_stat) stat_nxt = stat_q & wdata;
    if (upd_evt) stat_nxt[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      stat_q   <= '0;
      div_q    <= '0;
      reload_q <= '0;
    end else begin
      stat_q <= stat_nxt;
      if (wr && sel_ctrl) ctrl_q   <= wdata;
      if (wr && sel_ien)  ien_q    <= wdata;
      if (wr && sel_div)  div_q    <= wdata;
      if (wr && sel_rel)  reload_q <= wdata;
    end
  end

  assign cen        = ctrl_q[0];
  assign ien_ok     = (ien_q == DW'(IEN_ARMED));
  assign stat_flag  = stat_q[0];
  assign div_val    = div_q;
  assign reload_val = reload_q;
  assign hit        = sel_ctrl | sel_ien | sel_stat | sel_div | sel_rel;

  always_comb begin
    rdata = '0;
    if (sel_ctrl) rdata = ctrl_q;
    if (sel_ien)  rdata = ien_q;
    if (sel_stat) rdata = stat_q;
    if (sel_div)  rdata = div_q;
    if (sel_rel)  rdata = reload_q;
  end
endmodule

// File: rtl/gpt_count_engine.sv
module gpt_count_engine #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cen,
  input  logic [DW-1:0] div_val,
  input  logic [DW-1:0] reload_val,
  input  logic          cnt_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_val,
  output logic          reach
);
  logic [DW-1:0] pre_q, cnt_q, cnt_inc;
  logic          tick, at_or_past;

  assign tick       = cen && (pre_q >= div_val);
  assign cnt_inc    = cnt_q + 1'b1;
  assign at_or_past = (reload_val == '0) || (cnt_q >= reload_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cen) pre_q <= tick ? '0 : pre_q + 1'b1;
      if (cnt_wr)
        cnt_q <= wdata;
      else if (tick)
        cnt_q <= at_or_past ? '0 : cnt_inc;
    end
  end

  assign reach   = tick && !cnt_wr && !at_or_past && (cnt_inc == reload_val);
  assign cnt_val = cnt_q;
endmodule

// File: rtl/gpt_interval_timer.sv
module gpt_interval_timer
  import gpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAP_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_out
);
  logic          plain_hit, ctrl_hit, cnt_hit, mapped;
  logic [DW-1:0] plain_rd, ctrl_rd, cnt_val, div_val, reload_val;
  logic          ctrl_en, ien_ok, stat_flag, reach, upd_evt, irq_q;

  assign cnt_hit = (bus_addr == A_COUNT);
  assign upd_evt = reach && ien_ok && ctrl_en;

  gpt_plain_bank #(.DW(DW), .N(N_PLAIN)) u_bank (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .hit(plain_hit), .rdata(plain_rd)
  );

  gpt_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .upd_evt(upd_evt), .cen(ctrl_en), .ien_ok(ien_ok), .stat_flag(stat_flag),
    .div_val(div_val), .reload_val(reload_val), .hit(ctrl_hit), .rdata(ctrl_rd)
  );

  gpt_count_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .cen(ctrl_en), .div_val(div_val),
    .reload_val(reload_val), .cnt_wr(bus_wr && cnt_hit), .wdata(bus_wdata),
    .cnt_val(cnt_val), .reach(reach)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= upd_evt;
  end

  assign mapped    = plain_hit | ctrl_hit | cnt_hit;
  assign bus_rdata = plain_rd | ctrl_rd | (cnt_hit ? cnt_val : '0);
  assign irq_out   = irq_q;
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
  import gpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [MAP_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_rdata,
  input logic              irq_out,
  input logic              mapped,
  input logic              ctrl_en,
  input logic              ien_ok,
  input logic              stat_flag,
  input logic [DW-1:0]     cnt_val,
  input logic [DW-1:0]     reload_val
);
  logic cnt_write;
  assign cnt_write = bus_wr && (bus_addr == A_COUNT);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |=> !irq_out);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(ien_ok) && $past(ctrl_en) && stat_flag));

  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (bus_rdata == '0));

  // R4
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !cnt_write) |=> $stable(cnt_val));

  // R9
  zero_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_val == '0) |=> !irq_out);
endmodule

bind gpt_interval_timer gpt_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .mapped(mapped),
  .ctrl_en(ctrl_en), .ien_ok(ien_ok), .stat_flag(stat_flag),
  .cnt_val(cnt_val), .reload_val(reload_val)
);

// File: tb/gpt_interval_timer_bench.sv
module gpt_interval_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;
  // {write offset, write data, read offset, expected}
  localparam logic [77:0] VEC [NV] = '{
    {7'h04, 32'hA5A5_0001, 7'h04, 32'hA5A5_0001},
    {7'h08, 32'h0000_1234, 7'h08, 32'h0000_1234},
    {7'h14, 32'h0000_0055, 7'h14, 32'h0000_0055},
    {7'h18, 32'h1111_2222, 7'h18, 32'h1111_2222},
    {7'h1C, 32'h3333_4444, 7'h1C, 32'h3333_4444},
    {7'h20, 32'h0000_F0F0, 7'h20, 32'h0000_F0F0},
    {7'h34, 32'hDEAD_BEEF, 7'h34, 32'hDEAD_BEEF},
    {7'h38, 32'hCAFE_0000, 7'h38, 32'hCAFE_0000},
    {7'h3C, 32'h0BAD_F00D, 7'h3C, 32'h0BAD_F00D},
    {7'h40, 32'h7777_8888, 7'h40, 32'h7777_8888},
    {7'h48, 32'h0000_0F01, 7'h48, 32'h0000_0F01},
    {7'h4C, 32'h0000_00AA, 7'h4C, 32'h0000_00AA},
    {7'h50, 32'h0000_0003, 7'h50, 32'h0000_0003},
    {7'h0C, 32'h0000_0002, 7'h0C, 32'h0000_0002},
    {7'h28, 32'h0000_0009, 7'h28, 32'h0000_0009},
    {7'h2C, 32'h0001_0000, 7'h2C, 32'h0001_0000},
    {7'h00, 32'hFFFF_FFFE, 7'h00, 32'hFFFF_FFFE},
    {7'h30, 32'hFFFF_FFFF, 7'h30, 32'h0000_0000},
    {7'h44, 32'h1234_5678, 7'h40, 32'h7777_8888},
    {7'h54, 32'hFFFF_FFFF, 7'h50, 32'h0000_0003},
    {7'h01, 32'hFFFF_FFFF, 7'h00, 32'hFFFF_FFFE},
    {7'h7C, 32'h0000_0001, 7'h7C, 32'h0000_0000}
  };
  localparam logic [6:0] ALL_OFS [19] = '{
    7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14, 7'h18, 7'h1C, 7'h20, 7'h24,
    7'h28, 7'h2C, 7'h34, 7'h38, 7'h3C, 7'h40, 7'h48, 7'h4C, 7'h50
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpt_interval_timer u_gpt_interval_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0;
    wait_cycles(2);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    int pulses;
    do_reset();

    // R1: every register zero, interrupt low
    for (int i = 0; i < 19; i++) begin
      bus_read(ALL_OFS[i], rd);
      check($sformatf("R1 offset %h", ALL_OFS[i]), rd, 32'h0);
    end
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // R2 / R3 vector walk
    for (int v = 0; v < NV; v++) begin
      bus_write(VEC[v][77:71], VEC[v][70:39]);
      bus_read(VEC[v][38:32], rd);
      check($sformatf("%s vec %0d", (v < 17) ? "R2" : "R3", v), rd, VEC[v][31:0]);
    end

    // R5: divide by 3, R4: hold when disabled
    do_reset();
    bus_write(7'h28, 32'd2);
    bus_write(7'h2C, 32'd100);
    bus_write(7'h00, 32'h1);
    wait_cycles(3);
    bus_read(7'h24, rd);
    check("R5 first step", rd, 32'd1);
    wait_cycles(6);
    bus_read(7'h24, rd);
    check("R5 third step", rd, 32'd3);
    bus_write(7'h00, 32'h0);
    bus_read(7'h24, rd);
    wait_cycles(10);
    bus_read(7'h24, rd2);
    check("R4 hold", rd2, rd);

    // R7 / R6: event timing with limit 3, divider 0
    do_reset();
    bus_write(7'h0C, 32'h1);
    bus_write(7'h2C, 32'd3);
    bus_write(7'h00, 32'h1);
    wait_cycles(2);
    bus_read(7'h24, rd);
    check("R7 before reach count", rd, 32'd2);
    check("R7 before reach irq", {31'b0, irq_out}, 32'h0);
    wait_cycles(1);
    check("R7 irq pulse", {31'b0, irq_out}, 32'h1);
    bus_read(7'h24, rd);
    check("R7 count at limit", rd, 32'd3);
    bus_read(7'h10, rd);
    check("R7 flag set", rd, 32'h1);
    wait_cycles(1);
    check("R7 pulse one cycle", {31'b0, irq_out}, 32'h0);
    bus_read(7'h24, rd);
    check("R6 wrap to zero", rd, 32'd0);

    // R8: write-AND on the status word
    bus_write(7'h00, 32'h0);
    bus_write(7'h10, 32'hFFFF_FFFF);
    bus_read(7'h10, rd);
    check("R8 write one keeps", rd, 32'h1);
    bus_write(7'h10, 32'hFFFF_FFFE);
    bus_read(7'h10, rd);
    check("R8 write zero clears", rd, 32'h0);

    // R7: enable word other than 0x1 gives nothing
    do_reset();
    bus_write(7'h0C, 32'h3);
    bus_write(7'h2C, 32'd2);
    bus_write(7'h00, 32'h1);
    pulses = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (irq_out) pulses++;
    end
    check("R7 enable 0x3 pulses", pulses, 0);
    bus_read(7'h10, rd);
    check("R7 enable 0x3 flag", rd, 32'h0);

    // R9: limit zero
    do_reset();
    bus_write(7'h0C, 32'h1);
    bus_write(7'h00, 32'h1);
    pulses = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (irq_out) pulses++;
    end
    check("R9 pulses", pulses, 0);
    bus_read(7'h24, rd);
    check("R9 count", rd, 32'd0);
    bus_read(7'h10, rd);
    check("R9 flag", rd, 32'h0);

    // R10: software counter load
    do_reset();
    bus_write(7'h0C, 32'h1);
    bus_write(7'h2C, 32'd50);
    bus_write(7'h24, 32'd48);
    bus_read(7'h24, rd);
    check("R10 load readback", rd, 32'd48);
    bus_write(7'h00, 32'h1);
    wait_cycles(1);
    check("R10 no early pulse", {31'b0, irq_out}, 32'h0);
    wait_cycles(1);
    check("R10 pulse from loaded value", {31'b0, irq_out}, 32'h1);
    bus_read(7'h24, rd);
    check("R10 count at limit", rd, 32'd50);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule